// File: doc/BRIEF.md
# Display Auxiliary Channel Request Bridge

This block serves requests on the auxiliary channel of a display link at the request level, one at a time. Each request carries a 4-bit command, a 20-bit address and a byte count. The payload moves through two byte streams. Write bytes enter on a valid/ready stream and are pulled one at a time, only when the next operation needs one, so the producer can stall the bridge by holding `wr_valid` low. Read bytes leave on a second valid/ready stream. Each read byte is held on `rd_data` until the consumer raises `rd_ready`, and the bridge waits for that before it starts the next access.

Native requests go to a byte-wide register port. I2C-over-AUX requests become start, byte and stop operations on an abstract I2C master port. Both ports use the same handshake: the bridge raises a command valid and holds its fields, and the port answers with a response valid carrying an error flag (and read data). Across requests the bridge remembers whether the I2C bus is open, and the address and command of the last middle-of-transaction request. A continuing request can then reuse the open transfer without another start.

Every request ends with a one-cycle `rsp_valid` pulse. `rsp_code` carries the reply and holds it until the next reply.

Top module: `aux_i2c_bridge`

## Requirements
- R1: The command code works as follows. Bit 3 set means native and clear means I2C. Bit 2 set means middle-of-transaction. Bits 1:0 are 00 for write and 01 for read. Only 0x0, 0x1, 0x4, 0x5, 0x8 and 0x9 are legal. Any other code replies NACK in the cycle after acceptance and issues no operation on either port.
- R2: A native request makes one register access per byte. The first access is at the request address, and the address increases by one after each byte, wrapping at 20 bits. A request with a count of zero replies ACK with no access.
- R3: A register access that returns an error ends a native request at once with a NACK reply. No further access follows. When every access succeeds the reply is ACK.
- R4: A plain I2C request (bit 2 clear) behaves as follows. If the bus is open, it first issues a stop. It then issues a start with the low 7 address bits and the direction from bit 0. A failed start replies I2C NACK and issues no stop. Otherwise the bytes are moved and a stop always closes the transfer.
- R5: In a plain I2C request, a failed byte ends the byte phase, and a stop follows before the I2C NACK reply. This holds for the last byte too.
- R6: A middle-of-transaction request on an idle bus issues a start. If the start fails, it replies I2C NACK.
- R7: A middle-of-transaction request on an open bus continues without a stop or start when both its full address and its command equal the stored ones. Otherwise it issues a stop, then a start.
- R8: After a successful middle-of-transaction setup, the bridge stores the address and command. Success replies ACK and leaves the bus open. A failed byte issues a stop and replies I2C NACK.
- R9: Reply codes are 00 for ACK, 01 for NACK and 10 for I2C NACK. `rsp_valid` is high for exactly one cycle. A new request is accepted only while no request is in progress.
- R10: A start is never issued while the bus is open. A successful start opens the bus, and any stop closes it.
- R11: A port command stays valid, with stable fields, until the cycle its response arrives.
- R12: A read byte stays on `rd_data` with `rd_valid` high until `rd_ready` is seen.
- R13: Synchronous reset closes the bus and clears the stored address and command, so the first I2C request after reset issues no stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle, takes the request |
| req_cmd | input | 4 | Command code (R1) |
| req_addr | input | 20 | Request address |
| req_len | input | 5 | Byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Bridge takes a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| rsp_valid | output | 1 | One-cycle reply pulse |
| rsp_code | output | 2 | Reply code (R9) |
| reg_valid | output | 1 | Register access pending |
| reg_write | output | 1 | Access is a write |
| reg_addr | output | 20 | Access address |
| reg_wdata | output | 8 | Write byte |
| reg_rsp_valid | input | 1 | Access complete |
| reg_rsp_err | input | 1 | Access failed |
| reg_rsp_rdata | input | 8 | Read byte |
| i2c_cmd_valid | output | 1 | I2C operation pending |
| i2c_cmd_op | output | 2 | 0 start, 1 byte, 2 stop |
| i2c_cmd_addr | output | 7 | Target address for start |
| i2c_cmd_read | output | 1 | Direction for start and byte |
| i2c_cmd_wdata | output | 8 | Byte to send |
| i2c_rsp_valid | input | 1 | Operation complete |
| i2c_rsp_err | input | 1 | Operation failed |
| i2c_rsp_rdata | input | 8 | Byte received |

## Verification
The two events that can land in one cycle are the byte counter reaching its end and a byte error. A failure placed on the final byte of a transfer must still produce a stop and an I2C NACK, not an ACK. Byte failures are injected at the first, middle and last index. The reference model predicts each port operation, read byte and reply, and the bench compares them as they appear. Read back-pressure also makes a held read byte overlap the cycles where the next access would otherwise start, which checks that no access begins before the byte has left.

// File: rtl/aux_bridge_pkg.sv
package aux_bridge_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    RSP_ACK      = 2'b00,
    RSP_NACK     = 2'b01,
    RSP_I2C_NACK = 2'b10
  } reply_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } i2c_op_e;

  typedef struct packed {
    logic legal;
    logic native;
    logic mot;
    logic read;
  } cmd_info_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE_STOP,
    S_START,
    S_NEXT,
    S_WR_WAIT,
    S_REG_OP,
    S_I2C_BYTE,
    S_RD_OUT,
    S_END_STOP,
    S_REPLY
  } state_e;

endpackage

// File: rtl/aux_cmd_decode.sv
module aux_cmd_decode
  import aux_bridge_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output cmd_info_t        info
);
  // bit 3: native, bit 2: continue flag, bits 1:0: 00 write / 01 read
  always_comb begin
    info.native = cmd[3];
    info.mot    = cmd[2];
    info.read   = cmd[0];
    info.legal  = (cmd[1] == 1'b0) && !(cmd[3] && cmd[2]);
  end
endmodule

// File: rtl/aux_i2c_session.sv
module aux_i2c_session #(
  parameter int ADDR_W = 20,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_set,
  input  logic              open_clr,
  input  logic              store,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [CMD_W-1:0]  st_cmd,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [CMD_W-1:0]  cmp_cmd,
  output logic              busy,
  output logic              same
);
  logic [ADDR_W-1:0] last_addr;
  logic [CMD_W-1:0]  last_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      last_addr <= '0;
      last_cmd  <= '0;
    end else begin
      if (open_clr)      busy <= 1'b0;
      else if (open_set) busy <= 1'b1;
      if (store) begin
        last_addr <= st_addr;
        last_cmd  <= st_cmd;
      end
    end
  end

  assign same = (last_addr == cmp_addr) && (last_cmd == cmp_cmd);
endmodule

// File: rtl/aux_xfer_count.sv
module aux_xfer_count #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  count,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              empty
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain   <= '0;
      cur_addr <= '0;
    end else if (load) begin
      remain   <= count;
      cur_addr <= base_addr;
    end else if (step) begin
      remain   <= remain - LEN_W'(1);
      cur_addr <= cur_addr + ADDR_W'(1);
    end
  end

  assign empty = (remain == '0);
endmodule

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge
  import aux_bridge_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5,
  parameter int I2C_AW = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic              reg_valid,
  output logic              reg_write,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rsp_valid,
  input  logic              reg_rsp_err,
  input  logic [DATA_W-1:0] reg_rsp_rdata,
  output logic              i2c_cmd_valid,
  output logic [1:0]        i2c_cmd_op,
  output logic [I2C_AW-1:0] i2c_cmd_addr,
  output logic              i2c_cmd_read,
  output logic [DATA_W-1:0] i2c_cmd_wdata,
  input  logic              i2c_rsp_valid,
  input  logic              i2c_rsp_err,
  input  logic [DATA_W-1:0] i2c_rsp_rdata
);

  state_e            state;
  reply_e            code_q;
  cmd_info_t         dec;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              native_q, mot_q, read_q;
  logic [DATA_W-1:0] dbuf;
  logic              sess_busy, sess_same;
  logic              cnt_load, cnt_step, cnt_empty;
  logic              open_set, open_clr, is_stop;
  logic [ADDR_W-1:0] cur_addr;

  aux_cmd_decode u_dec (
    .cmd  (req_cmd),
    .info (dec)
  );

  assign is_stop  = (state == S_PRE_STOP) || (state == S_END_STOP);
  assign open_set = (state == S_START) && i2c_rsp_valid && !i2c_rsp_err;
  assign open_clr = is_stop && i2c_rsp_valid;

  aux_i2c_session #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_sess (
    .clk      (clk),
    .rst      (rst),
    .open_set (open_set),
    .open_clr (open_clr),
    .store    (open_set && mot_q),
    .st_addr  (addr_q),
    .st_cmd   (cmd_q),
    .cmp_addr (req_addr),
    .cmp_cmd  (req_cmd),
    .busy     (sess_busy),
    .same     (sess_same)
  );

  assign cnt_load = (state == S_IDLE) && req_valid;
  assign cnt_step = ((state == S_REG_OP) && reg_rsp_valid && !reg_rsp_err) ||
                    ((state == S_I2C_BYTE) && i2c_rsp_valid && !i2c_rsp_err);

  aux_xfer_count #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (cnt_load),
    .step      (cnt_step),
    .base_addr (req_addr),
    .count     (req_len),
    .cur_addr  (cur_addr),
    .empty     (cnt_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      code_q   <= RSP_ACK;
      cmd_q    <= '0;
      addr_q   <= '0;
      native_q <= 1'b0;
      mot_q    <= 1'b0;
      read_q   <= 1'b0;
      dbuf     <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          cmd_q    <= req_cmd;
          addr_q   <= req_addr;
          native_q <= dec.native;
          mot_q    <= dec.mot;
          read_q   <= dec.read;
          if (!dec.legal) begin
            code_q <= RSP_NACK;
            state  <= S_REPLY;
          end else if (dec.native)            state <= S_NEXT;
          else if (!sess_busy)                state <= S_START;
          else if (dec.mot && sess_same)      state <= S_NEXT;
          else                                state <= S_PRE_STOP;
        end
        S_PRE_STOP: if (i2c_rsp_valid) state <= S_START;
        S_START: if (i2c_rsp_valid) begin
          if (i2c_rsp_err) begin
            code_q <= RSP_I2C_NACK;
            state  <= S_REPLY;
          end else begin
            state  <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (cnt_empty) begin
            code_q <= RSP_ACK;
            state  <= (!native_q && !mot_q) ? S_END_STOP : S_REPLY;
          end else if (!read_q) begin
            state  <= S_WR_WAIT;
          end else begin
            state  <= native_q ? S_REG_OP : S_I2C_BYTE;
          end
        end
        S_WR_WAIT: if (wr_valid) begin
          dbuf  <= wr_data;
          state <= native_q ? S_REG_OP : S_I2C_BYTE;
        end
        S_REG_OP: if (reg_rsp_valid) begin
          if (reg_rsp_err) begin
            code_q <= RSP_NACK;
            state  <= S_REPLY;
          end else if (read_q) begin
            dbuf   <= reg_rsp_rdata;
            state  <= S_RD_OUT;
          end else begin
            state  <= S_NEXT;
          end
        end
        S_I2C_BYTE: if (i2c_rsp_valid) begin
          if (i2c_rsp_err) begin
            code_q <= RSP_I2C_NACK;
            state  <= S_END_STOP;
          end else if (read_q) begin
            dbuf   <= i2c_rsp_rdata;
            state  <= S_RD_OUT;
          end else begin
            state  <= S_NEXT;
          end
        end
        S_RD_OUT:   if (rd_ready) state <= S_NEXT;
        S_END_STOP: if (i2c_rsp_valid) state <= S_REPLY;
        S_REPLY:    state <= S_IDLE;
        default:    state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign wr_ready      = (state == S_WR_WAIT);
  assign rd_valid      = (state == S_RD_OUT);
  assign rd_data       = dbuf;
  assign rsp_valid     = (state == S_REPLY);
  assign rsp_code      = code_q;
  assign reg_valid     = (state == S_REG_OP);
  assign reg_write     = !read_q;
  assign reg_addr      = cur_addr;
  assign reg_wdata     = dbuf;
  assign i2c_cmd_valid = is_stop || (state == S_START) || (state == S_I2C_BYTE);
  assign i2c_cmd_op    = is_stop ? OP_STOP : ((state == S_START) ? OP_START : OP_BYTE);
  assign i2c_cmd_addr  = addr_q[I2C_AW-1:0];
  assign i2c_cmd_read  = read_q;
  assign i2c_cmd_wdata = dbuf;

endmodule

// File: rtl/aux_i2c_bridge_chk.sv
module aux_i2c_bridge_chk #(
  parameter int ADDR_W = 20,
  parameter int I2C_AW = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_cmd,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic              reg_valid,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rsp_valid,
  input logic              reg_rsp_err,
  input logic              i2c_cmd_valid,
  input logic [1:0]        i2c_cmd_op,
  input logic [I2C_AW-1:0] i2c_cmd_addr,
  input logic              i2c_rsp_valid,
  input logic              i2c_rsp_err
);
  logic              legal;
  logic              sh_open;
  logic              have_prev;
  logic [ADDR_W-1:0] nxt_addr;

  assign legal = (req_cmd == 4'h0) || (req_cmd == 4'h1) || (req_cmd == 4'h4) ||
                 (req_cmd == 4'h5) || (req_cmd == 4'h8) || (req_cmd == 4'h9);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_open   <= 1'b0;
      have_prev <= 1'b0;
      nxt_addr  <= '0;
    end else begin
      if (i2c_cmd_valid && i2c_rsp_valid) begin
        if (i2c_cmd_op == 2'd0 && !i2c_rsp_err) sh_open <= 1'b1;
        else if (i2c_cmd_op == 2'd2)            sh_open <= 1'b0;
      end
      if (req_valid && req_ready) have_prev <= 1'b0;
      else if (reg_valid && reg_rsp_valid && !reg_rsp_err) begin
        have_prev <= 1'b1;
        nxt_addr  <= reg_addr + ADDR_W'(1);
      end
    end
  end

  p_bad_cmd_nack_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !legal |=> rsp_valid && rsp_code == 2'b01 && !reg_valid && !i2c_cmd_valid);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    reg_valid && have_prev |-> reg_addr == nxt_addr);

  p_reg_err_nack_r3: assert property (@(posedge clk) disable iff (rst)
    reg_valid && reg_rsp_valid && reg_rsp_err |=> rsp_valid && rsp_code == 2'b01);

  p_byte_err_stop_r5: assert property (@(posedge clk) disable iff (rst)
    i2c_cmd_valid && i2c_cmd_op == 2'd1 && i2c_rsp_valid && i2c_rsp_err |=> i2c_cmd_valid && i2c_cmd_op == 2'd2);

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !reg_valid && !i2c_cmd_valid && !rsp_valid);

  p_no_start_open_r10: assert property (@(posedge clk) disable iff (rst)
    i2c_cmd_valid && i2c_cmd_op == 2'd0 |-> !sh_open);

  p_i2c_hold_r11: assert property (@(posedge clk) disable iff (rst)
    i2c_cmd_valid && !i2c_rsp_valid |=> i2c_cmd_valid && $stable(i2c_cmd_op) && $stable(i2c_cmd_addr));

  p_reg_hold_r11: assert property (@(posedge clk) disable iff (rst)
    reg_valid && !reg_rsp_valid |=> reg_valid && $stable(reg_addr));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
endmodule

bind aux_i2c_bridge aux_i2c_bridge_chk #(.ADDR_W(ADDR_W), .I2C_AW(I2C_AW), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/aux_i2c_bridge_test.sv
module aux_i2c_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [3:0]  req_cmd = '0;
  logic [19:0] req_addr = '0;
  logic [4:0]  req_len = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [7:0]  wr_data = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic        reg_valid, reg_write;
  logic [19:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_rsp_valid = 1'b0, reg_rsp_err = 1'b0;
  logic [7:0]  reg_rsp_rdata = '0;
  logic        i2c_cmd_valid, i2c_cmd_read;
  logic [1:0]  i2c_cmd_op;
  logic [6:0]  i2c_cmd_addr;
  logic [7:0]  i2c_cmd_wdata;
  logic        i2c_rsp_valid = 1'b0, i2c_rsp_err = 1'b0;
  logic [7:0]  i2c_rsp_rdata = '0;

  always #10 clk = ~clk;

  aux_i2c_bridge uut (.*);

  int n_chk = 0, n_fail = 0;
  string tag = "reset";
  longint exp_ops[$];
  logic [7:0] exp_rd[$];
  logic [1:0] exp_rsp[$];
  logic [7:0] wq[$];
  logic [7:0] mmem [int];
  logic [7:0] smem [int];
  int reg_fail_addr = -1;
  int byte_fail_idx = -1;
  int byte_idx = 0;
  int s_rd_cnt = 0, m_rd_cnt = 0;
  int cyc = 0;
  bit m_busy = 0;
  logic [19:0] m_last_addr = '0;
  logic [3:0]  m_last_cmd = '0;
  bit got_rsp = 0;
  bit wr_pend = 0;
  bit finished = 0;

  function automatic longint enc(int kind, bit rd, logic [19:0] a, logic [7:0] d);
    return (longint'(kind) << 32) | (longint'(rd) << 28) | (longint'(a) << 8) | longint'(d);
  endfunction

  function automatic logic [7:0] reg_default(int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic bit start_fails(logic [6:0] a);
    return a >= 7'h70;
  endfunction

  task automatic chk(bit ok, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic see_op(longint obs);
    longint e;
    if (exp_ops.size() == 0) chk(0, "unexpected port operation", obs, 0);
    else begin
      e = exp_ops.pop_front();
      chk(obs == e, "port operation", obs, e);
    end
  endtask

  // Reference model: predicts port operations, read bytes and the reply
  task automatic model_req(logic [3:0] cmd, logic [19:0] addr, int len, logic [7:0] base);
    bit rd, mot, need_start;
    int a;
    logic [7:0] w, v;
    rd = cmd[0];
    mot = cmd[2];
    if (!(cmd inside {4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9})) begin
      exp_rsp.push_back(2'b01);
      return;
    end
    if (cmd[3]) begin
      for (int i = 0; i < len; i++) begin
        a = int'(addr + 20'(i));
        w = base + 8'(i * 7);
        if (!rd) wq.push_back(w);
        exp_ops.push_back(enc(3, rd, 20'(a), rd ? 8'h00 : w));
        if (a == reg_fail_addr) begin exp_rsp.push_back(2'b01); return; end
        if (rd) begin
          v = mmem.exists(a) ? mmem[a] : reg_default(a);
          exp_rd.push_back(v);
        end else mmem[a] = w;
      end
      exp_rsp.push_back(2'b00);
      return;
    end
    need_start = 1;
    if (m_busy) begin
      if (mot && addr == m_last_addr && cmd == m_last_cmd) need_start = 0;
      else begin exp_ops.push_back(enc(2, 0, 0, 0)); m_busy = 0; end
    end
    if (need_start) begin
      exp_ops.push_back(enc(0, rd, {13'h0, addr[6:0]}, 0));
      if (start_fails(addr[6:0])) begin exp_rsp.push_back(2'b10); return; end
      m_busy = 1;
    end
    if (mot) begin m_last_addr = addr; m_last_cmd = cmd; end
    for (int i = 0; i < len; i++) begin
      w = base + 8'(i * 7);
      if (!rd) wq.push_back(w);
      exp_ops.push_back(enc(1, rd, 0, rd ? 8'h00 : w));
      if (i == byte_fail_idx) begin
        exp_ops.push_back(enc(2, 0, 0, 0));
        m_busy = 0;
        exp_rsp.push_back(2'b10);
        return;
      end
      if (rd) begin exp_rd.push_back(8'h30 + 8'(m_rd_cnt)); m_rd_cnt++; end
    end
    if (!mot) begin exp_ops.push_back(enc(2, 0, 0, 0)); m_busy = 0; end
    exp_rsp.push_back(2'b00);
  endtask

  // Port responders, stream drivers and monitors, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (wr_pend) void'(wq.pop_front());
      wr_valid = !rst && (wq.size() > 0) && finished == 0;
      wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
      wr_pend  = wr_valid && wr_ready;
      rd_ready = (cyc % 3) != 0;
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0) chk(0, "R12 unexpected read byte", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rd.pop_front();
          chk(rd_data == e, "read byte", rd_data, e);
        end
      end
      if (rsp_valid) begin
        got_rsp = 1;
        if (exp_rsp.size() == 0) chk(0, "R9 unexpected reply", rsp_code, 0);
        else begin
          logic [1:0] e;
          e = exp_rsp.pop_front();
          chk(rsp_code == e, "reply code", rsp_code, e);
        end
      end
      if (reg_rsp_valid) reg_rsp_valid = 0;
      else if (reg_valid) begin
        int a;
        a = int'(reg_addr);
        see_op(enc(3, !reg_write, reg_addr, reg_write ? reg_wdata : 8'h00));
        reg_rsp_err = (a == reg_fail_addr);
        if (!reg_rsp_err) begin
          if (reg_write) smem[a] = reg_wdata;
          else reg_rsp_rdata = smem.exists(a) ? smem[a] : reg_default(a);
        end
        reg_rsp_valid = 1;
      end
      if (i2c_rsp_valid) i2c_rsp_valid = 0;
      else if (i2c_cmd_valid) begin
        i2c_rsp_err = 0;
        case (i2c_cmd_op)
          2'd0: begin
            see_op(enc(0, i2c_cmd_read, {13'h0, i2c_cmd_addr}, 0));
            i2c_rsp_err = start_fails(i2c_cmd_addr);
          end
          2'd1: begin
            see_op(enc(1, i2c_cmd_read, 0, i2c_cmd_read ? 8'h00 : i2c_cmd_wdata));
            i2c_rsp_err = (byte_idx == byte_fail_idx);
            byte_idx++;
            if (!i2c_rsp_err && i2c_cmd_read) begin
              i2c_rsp_rdata = 8'h30 + 8'(s_rd_cnt);
              s_rd_cnt++;
            end
          end
          default: see_op(enc(2, 0, 0, 0));
        endcase
        i2c_rsp_valid = 1;
      end
    end
  end

  task automatic do_req(string t, logic [3:0] cmd, logic [19:0] addr, int len, logic [7:0] base);
    int guard;
    tag = t;
    byte_idx = 0;
    got_rsp = 0;
    model_req(cmd, addr, len, base);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_addr = addr; req_len = 5'(len);
    @(negedge clk);
    req_valid = 0;
    guard = 0;
    while (!got_rsp && guard < 2000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(got_rsp, "reply seen", got_rsp, 1);
    chk(exp_ops.size() == 0, "missing port operations", exp_ops.size(), 0);
    chk(exp_rd.size() == 0 && wq.size() == 0, "stream bytes left", exp_rd.size() + wq.size(), 0);
    exp_ops.delete(); exp_rd.delete(); exp_rsp.delete(); wq.delete();
    byte_fail_idx = -1;
    reg_fail_addr = -1;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_busy = 0;
    m_last_addr = '0;
    m_last_cmd = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    tag = "R13 R9 reset state";
    chk(req_ready == 1 && rsp_valid == 0, "idle outputs", {req_ready, rsp_valid}, 2'b10);
    chk(reg_valid == 0 && i2c_cmd_valid == 0, "ports quiet", {reg_valid, i2c_cmd_valid}, 0);

    do_req("R2 native write", 4'h8, 20'h00010, 4, 8'h11);
    do_req("R2 native read back", 4'h9, 20'h00010, 4, 8'h00);
    do_req("R2 native write across wrap", 4'h8, 20'hFFFFE, 3, 8'hA0);
    do_req("R2 native read across wrap", 4'h9, 20'hFFFFE, 3, 8'h00);
    do_req("R2 native zero length", 4'h9, 20'h00100, 0, 8'h00);
    reg_fail_addr = 32'h12;
    do_req("R3 native read error", 4'h9, 20'h00010, 4, 8'h00);
    reg_fail_addr = 32'h40;
    do_req("R3 native write error first byte", 4'h8, 20'h00040, 2, 8'h77);
    do_req("R1 illegal code c", 4'hC, 20'h00010, 2, 8'h00);
    do_req("R1 illegal code 2", 4'h2, 20'h00050, 1, 8'h00);
    do_req("R1 illegal code b", 4'hB, 20'h00050, 1, 8'h00);

    do_req("R4 plain write", 4'h0, 20'h00050, 3, 8'h21);
    do_req("R4 R12 plain read", 4'h1, 20'h00050, 5, 8'h00);
    do_req("R4 plain start fail", 4'h0, 20'h00072, 2, 8'h00);
    do_req("R4 plain address only", 4'h1, 20'h00050, 0, 8'h00);
    byte_fail_idx = 1;
    do_req("R5 plain byte fail middle", 4'h0, 20'h00050, 3, 8'h40);
    byte_fail_idx = 2;
    do_req("R5 plain byte fail last", 4'h0, 20'h00050, 3, 8'h48);
    byte_fail_idx = 0;
    do_req("R5 plain read fail first", 4'h1, 20'h00050, 2, 8'h00);

    do_req("R6 R8 mot write on idle bus", 4'h4, 20'h00050, 2, 8'h60);
    do_req("R7 mot write same target", 4'h4, 20'h00050, 1, 8'h68);
    do_req("R7 mot read new command", 4'h5, 20'h00050, 2, 8'h00);
    do_req("R7 mot read new address", 4'h5, 20'h00051, 1, 8'h00);
    do_req("R7 mot upper address differs", 4'h5, 20'h10051, 1, 8'h00);
    do_req("R7 R8 mot zero length same", 4'h5, 20'h10051, 0, 8'h00);
    byte_fail_idx = 1;
    do_req("R8 mot byte fail", 4'h5, 20'h10051, 2, 8'h00);
    do_req("R6 mot start fail", 4'h4, 20'h00075, 1, 8'h00);
    do_req("R8 mot reopen", 4'h4, 20'h00050, 1, 8'h70);
    do_req("R4 plain closes open bus", 4'h1, 20'h00050, 1, 8'h00);
    do_req("R8 mot open before reset", 4'h4, 20'h00050, 1, 8'h80);
    do_reset();
    do_req("R13 no stop after reset", 4'h0, 20'h00050, 1, 8'h90);
    do_req("R13 mot after reset starts", 4'h4, 20'h00050, 1, 8'h98);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule